// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Fast-Line Routing

This block collects 64 peripheral interrupt lines and 8 local interrupt lines. All of them are level-sensitive, and none is latched. A source counts as pending while its input is high and its mask bit is set. The block drives two outputs:

- `irq_o`, the OR of every pending source.
- `fiq_o`, which follows the raw level of one source picked by software, whatever the masks say.

Software reaches the block over a plain 32-bit register bus, with a write strobe, a read strobe and a registered read result. Mask bits are never written directly. Software sets them with write-one-to-set registers and clears them with write-one-to-clear registers. A summary register gives interrupt handlers a quick view of the sources in one read: the masked local sources, one "any pending" flag for each 32-line peripheral group, and copies of eleven fixed peripheral lines.

Both outputs come from flops, one clock behind their inputs. Register reads return their data one clock after the read strobe.

Top module: `lvl_intc`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears both masks, the fast-line enable, the fast-line select, `irq_o`, `fiq_o` and `bus_rdata`.
- R2: A write to 0x10, 0x14 or 0x18 sets every mask bit whose data bit is 1 and leaves the other mask bits unchanged. 0x10 covers peripheral lines 31:0 and 0x14 covers lines 63:32. 0x18 covers the 8 local lines and uses only data bits 7:0.
- R3: A write to 0x1C, 0x20 or 0x24 clears every mask bit whose data bit is 1, for the same three groups in the same order. A data bit of 0 leaves its mask bit unchanged.
- R4: Reading 0x10, 0x14 or 0x18 returns the current mask, zero-extended for the local group. Reading 0x1C, 0x20 or 0x24 returns the bitwise inverse of that 32-bit value.
- R5: Reading 0x04 returns peripheral levels 31:0 AND their mask bits. Reading 0x08 does the same for lines 63:32.
- R6: Reading 0x00 returns the summary word:
  - bits 7:0 are the masked local sources;
  - bit 8 is 1 when any masked line in 31:0 is pending;
  - bit 9 is 1 when any masked line in 63:32 is pending;
  - bits 10 to 20 copy masked peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order;
  - all other bits are 0.
- R7: `irq_o` equals, one clock later, the OR of every pending peripheral and local source.
- R8: Register 0x0C holds the select in bits 6:0 and the enable in bit 7, and reads back the same way. When the enable is 1, `fiq_o` equals, one clock later, the raw level of the selected line: peripheral line `sel` for a select of 0 to 63, or local line `sel-64` for a select of 64 to 71. The masks have no effect on it. When the enable is 0, `fiq_o` is 0.
- R9: A select value from 72 to 127 drives `fiq_o` low, even when the enable is 1.
- R10: `bus_rdata` shows the addressed data in the cycle after `bus_rd` is sampled high. It is 0 in the cycle after a cycle without a read. An unmapped or unaligned offset reads as 0. A read changes no state.
- R11: A write to 0x00, 0x04, 0x08 or any unmapped offset leaves both masks and the fast-line control unchanged.
- R12: When a read and a write of the same register fall in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_lvl | input | 64 | Peripheral interrupt levels |
| local_lvl | input | 8 | Local interrupt levels |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered OR of pending sources |
| fiq_o | output | 1 | Registered level of the selected fast line |

## Verification
Two events can land on the same clock edge: a mask write and a read of that same mask, or a mask write while the source it covers is high.

- **Read and write in one cycle.** The bench drives write and read to 0x10 in one cycle and expects the pre-write mask. It then reads again and expects the updated mask.
- **Mask change against `irq_o`.** While a local source is high, the bench disables its mask and samples `irq_o` on both sides of the edge. `irq_o` must stay high for one more cycle, because it was computed from the old mask, and then drop.
- **Fast line against the masks.** The bench walks the select encodings with every mask at zero, which shows that the fast line sees raw levels while `irq_o` stays low.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

  localparam int ADDR_W    = 12;
  localparam int FIQ_SEL_W = 7;
  localparam int NCOPY     = 11;
  localparam int COPY_BASE = 10;
  localparam int GRP_LO    = 8;
  localparam int GRP_HI    = 9;

  typedef enum logic [3:0] {
    REG_SUMMARY, REG_PEND_LO, REG_PEND_HI, REG_FIQ,
    REG_EN_LO,  REG_EN_HI,  REG_EN_LOC,
    REG_DIS_LO, REG_DIS_HI, REG_DIS_LOC,
    REG_NONE
  } reg_id_t;

  typedef struct packed {
    logic                 en;
    logic [FIQ_SEL_W-1:0] sel;
  } fiq_ctrl_t;

  // Byte offset to register identity; unaligned or unknown -> REG_NONE.
  function automatic reg_id_t reg_of(logic [ADDR_W-1:0] a);
    case (a)
      12'h000: return REG_SUMMARY;
      12'h004: return REG_PEND_LO;
      12'h008: return REG_PEND_HI;
      12'h00C: return REG_FIQ;
      12'h010: return REG_EN_LO;
      12'h014: return REG_EN_HI;
      12'h018: return REG_EN_LOC;
      12'h01C: return REG_DIS_LO;
      12'h020: return REG_DIS_HI;
      12'h024: return REG_DIS_LOC;
      default: return REG_NONE;
    endcase
  endfunction

  // Peripheral line mirrored into summary slot k.
  function automatic int copy_src(int k);
    case (k)
      0: return 7;   1: return 9;   2: return 10;  3: return 18;
      4: return 19;  5: return 53;  6: return 54;  7: return 55;
      8: return 56;  9: return 57;  default: return 62;
    endcase
  endfunction

endpackage

// File: rtl/lvl_intc_regs.sv
module lvl_intc_regs
  import lvl_intc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LOCAL_N = 8,
  localparam int PERIPH_N = 2 * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  reg_id_t             wr_id,
  input  logic [DATA_W-1:0]   wdata,
  output logic [PERIPH_N-1:0] pmask,
  output logic [LOCAL_N-1:0]  lmask,
  output fiq_ctrl_t           fiq_ctrl
);

  for (genvar w = 0; w < 2; w++) begin : g_word
    localparam reg_id_t SET_ID = (w == 0) ? REG_EN_LO  : REG_EN_HI;
    localparam reg_id_t CLR_ID = (w == 0) ? REG_DIS_LO : REG_DIS_HI;
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        q <= '0;
      else if (wr_en && wr_id == SET_ID) q <= q | wdata;
      else if (wr_en && wr_id == CLR_ID) q <= q & ~wdata;
    end
    assign pmask[w*DATA_W +: DATA_W] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             lmask <= '0;
    else if (wr_en && wr_id == REG_EN_LOC)  lmask <= lmask | wdata[LOCAL_N-1:0];
    else if (wr_en && wr_id == REG_DIS_LOC) lmask <= lmask & ~wdata[LOCAL_N-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         fiq_ctrl <= '0;
    else if (wr_en && wr_id == REG_FIQ) fiq_ctrl <= fiq_ctrl_t'(wdata[FIQ_SEL_W:0]);
  end

endmodule

// File: rtl/lvl_intc_status.sv
module lvl_intc_status
  import lvl_intc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LOCAL_N = 8,
  localparam int PERIPH_N = 2 * DATA_W
) (
  input  logic [PERIPH_N-1:0] plvl,
  input  logic [LOCAL_N-1:0]  llvl,
  input  logic [PERIPH_N-1:0] pmask,
  input  logic [LOCAL_N-1:0]  lmask,
  input  fiq_ctrl_t           fiq_ctrl,
  output logic [PERIPH_N-1:0] ppend,
  output logic [LOCAL_N-1:0]  lpend,
  output logic [DATA_W-1:0]   summary,
  output logic                any_pend,
  output logic                fiq_src
);

  logic [NCOPY-1:0] copies;

  assign ppend    = plvl & pmask;
  assign lpend    = llvl & lmask;
  assign any_pend = (|ppend) | (|lpend);

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    localparam int SRC = copy_src(k);
    assign copies[k] = ppend[SRC];
  end

  always_comb begin
    summary                     = '0;
    summary[LOCAL_N-1:0]        = lpend;
    summary[GRP_LO]             = |ppend[DATA_W-1:0];
    summary[GRP_HI]             = |ppend[PERIPH_N-1:DATA_W];
    summary[COPY_BASE +: NCOPY] = copies;
  end

  // Fast line reads raw levels; selects past the last local line give 0.
  always_comb begin
    fiq_src = 1'b0;
    for (int i = 0; i < PERIPH_N; i++)
      if (fiq_ctrl.sel == FIQ_SEL_W'(i)) fiq_src = plvl[i];
    for (int j = 0; j < LOCAL_N; j++)
      if (fiq_ctrl.sel == FIQ_SEL_W'(PERIPH_N + j)) fiq_src = llvl[j];
    if (!fiq_ctrl.en) fiq_src = 1'b0;
  end

endmodule

// File: rtl/lvl_intc_rdport.sv
module lvl_intc_rdport
  import lvl_intc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LOCAL_N = 8,
  localparam int PERIPH_N = 2 * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  reg_id_t             rd_id,
  input  logic [DATA_W-1:0]   summary,
  input  logic [PERIPH_N-1:0] ppend,
  input  logic [PERIPH_N-1:0] pmask,
  input  logic [LOCAL_N-1:0]  lmask,
  input  fiq_ctrl_t           fiq_ctrl,
  output logic [DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] lmask_ext;
  logic [DATA_W-1:0] nxt;

  assign lmask_ext = {{(DATA_W-LOCAL_N){1'b0}}, lmask};

  always_comb begin
    case (rd_id)
      REG_SUMMARY: nxt = summary;
      REG_PEND_LO: nxt = ppend[DATA_W-1:0];
      REG_PEND_HI: nxt = ppend[PERIPH_N-1:DATA_W];
      REG_FIQ:     nxt = {{(DATA_W-FIQ_SEL_W-1){1'b0}}, fiq_ctrl};
      REG_EN_LO:   nxt = pmask[DATA_W-1:0];
      REG_EN_HI:   nxt = pmask[PERIPH_N-1:DATA_W];
      REG_EN_LOC:  nxt = lmask_ext;
      REG_DIS_LO:  nxt = ~pmask[DATA_W-1:0];
      REG_DIS_HI:  nxt = ~pmask[PERIPH_N-1:DATA_W];
      REG_DIS_LOC: nxt = ~lmask_ext;
      default:     nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= nxt;
    else            rdata <= '0;
  end

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
  import lvl_intc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LOCAL_N = 8,
  localparam int PERIPH_N = 2 * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIPH_N-1:0] periph_lvl,
  input  logic [LOCAL_N-1:0]  local_lvl,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_o,
  output logic                fiq_o
);

  reg_id_t             acc_id;
  logic [PERIPH_N-1:0] pmask;
  logic [LOCAL_N-1:0]  lmask;
  fiq_ctrl_t           fiq_ctrl;
  logic [PERIPH_N-1:0] ppend;
  logic [LOCAL_N-1:0]  lpend;
  logic [DATA_W-1:0]   summary;
  logic                any_pend;
  logic                fiq_src;
  logic                irq_q;
  logic                fiq_q;

  assign acc_id = reg_of(bus_addr);

  lvl_intc_regs #(.DATA_W(DATA_W), .LOCAL_N(LOCAL_N)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .wr_id    (acc_id),
    .wdata    (bus_wdata),
    .pmask    (pmask),
    .lmask    (lmask),
    .fiq_ctrl (fiq_ctrl)
  );

  lvl_intc_status #(.DATA_W(DATA_W), .LOCAL_N(LOCAL_N)) u_status (
    .plvl     (periph_lvl),
    .llvl     (local_lvl),
    .pmask    (pmask),
    .lmask    (lmask),
    .fiq_ctrl (fiq_ctrl),
    .ppend    (ppend),
    .lpend    (lpend),
    .summary  (summary),
    .any_pend (any_pend),
    .fiq_src  (fiq_src)
  );

  lvl_intc_rdport #(.DATA_W(DATA_W), .LOCAL_N(LOCAL_N)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (bus_rd),
    .rd_id    (acc_id),
    .summary  (summary),
    .ppend    (ppend),
    .pmask    (pmask),
    .lmask    (lmask),
    .fiq_ctrl (fiq_ctrl),
    .rdata    (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= any_pend;
      fiq_q <= fiq_src;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk
  import lvl_intc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LOCAL_N = 8,
  localparam int PERIPH_N = 2 * DATA_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic [PERIPH_N-1:0] periph_lvl,
  input logic [LOCAL_N-1:0]  local_lvl,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_rd,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                irq_o,
  input logic                fiq_o,
  input logic [PERIPH_N-1:0] pmask,
  input logic [LOCAL_N-1:0]  lmask,
  input logic [FIQ_SEL_W:0]  fiq_ctrl
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  logic wr_set_lo, wr_clr_lo, wr_inert;
  assign wr_set_lo = bus_wr && bus_addr == 12'h010;
  assign wr_clr_lo = bus_wr && bus_addr == 12'h01C;
  assign wr_inert  = bus_wr && (bus_addr == 12'h000 || bus_addr == 12'h004 ||
                                bus_addr == 12'h008 || bus_addr == 12'h030);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    armed && !rst_n |=> pmask == '0 && lmask == '0 && fiq_ctrl == '0 &&
                        !irq_o && !fiq_o && bus_rdata == '0);

  // R2
  set_lo_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    wr_set_lo |=> (pmask[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata));

  // R3
  clr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    wr_clr_lo |=> (pmask[DATA_W-1:0] & $past(bus_wdata)) == '0);

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(rst_n) |-> irq_o == $past((|(periph_lvl & pmask)) || (|(local_lvl & lmask))));

  // R8
  fiq_off_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !fiq_ctrl[FIQ_SEL_W] |=> !fiq_o);

  // R9
  fiq_void_sel_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    fiq_ctrl[FIQ_SEL_W-1:0] >= FIQ_SEL_W'(PERIPH_N + LOCAL_N) |=> !fiq_o);

  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !bus_rd |=> bus_rdata == '0);

  // R11
  inert_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    wr_inert |=> $stable(pmask) && $stable(lmask) && $stable(fiq_ctrl));

endmodule

bind lvl_intc lvl_intc_chk #(.DATA_W(DATA_W), .LOCAL_N(LOCAL_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .periph_lvl (periph_lvl),
  .local_lvl  (local_lvl),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .pmask      (pmask),
  .lmask      (lmask),
  .fiq_ctrl   (fiq_ctrl)
);

// File: tb/test_lvl_intc.sv
module test_lvl_intc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] periph_lvl = '0;
  logic [7:0]  local_lvl = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  lvl_intc i_lvl_intc (
    .clk(clk), .rst_n(rst_n), .periph_lvl(periph_lvl), .local_lvl(local_lvl),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  // {fast-line control byte, expected fiq_o}; levels: periph 0,40,63 high, local 2 high, masks zero
  localparam logic [8:0] FIQ_VEC [10] = '{
    {8'h80, 1'b1}, {8'h81, 1'b0}, {8'hA8, 1'b1}, {8'hBF, 1'b1}, {8'hC2, 1'b1},
    {8'hC3, 1'b0}, {8'hC8, 1'b0}, {8'hFF, 1'b0}, {8'h00, 1'b0}, {8'h3F, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 fiq", {31'b0, fiq_o}, 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd(12'h010, v); chk("R1 mask lo", v, 32'h0);
    rd(12'h00C, v); chk("R1 fiq ctrl", v, 32'h0);
    rd(12'h024, v); chk("R1 R4 local disable view", v, 32'hFFFF_FFFF);

    // R8 / R9 fast-line table walk
    periph_lvl = 64'h8000_0100_0000_0001;
    local_lvl  = 8'h04;
    for (int k = 0; k < 10; k++) begin
      wr(12'h00C, {24'h0, FIQ_VEC[k][8:1]});
      @(negedge clk);
      chk((FIQ_VEC[k][8] && FIQ_VEC[k][7:1] >= 7'd72) ? "R9 fiq void select" : "R8 fiq select",
          {31'b0, fiq_o}, {31'b0, FIQ_VEC[k][0]});
      chk("R7 irq idle with zero masks", {31'b0, irq_o}, 32'h0);
    end
    rd(12'h00C, v); chk("R8 fiq ctrl readback", v, 32'h0000_003F);
    wr(12'h00C, 32'h0);

    // R2 / R4 set and inverse views
    wr(12'h010, 32'h0000_0081);
    wr(12'h010, 32'h0000_0100);
    rd(12'h010, v); chk("R2 set lo accumulates", v, 32'h0000_0181);
    rd(12'h01C, v); chk("R4 disable lo inverse", v, 32'hFFFF_FE7E);
    wr(12'h018, 32'hFFFF_FF03);
    rd(12'h018, v); chk("R2 local uses 7:0", v, 32'h0000_0003);
    rd(12'h024, v); chk("R4 disable local inverse", v, 32'hFFFF_FFFC);

    // R3 clear
    wr(12'h01C, 32'h0000_0001);
    rd(12'h010, v); chk("R3 clear lo", v, 32'h0000_0180);
    wr(12'h01C, 32'h0);
    rd(12'h010, v); chk("R3 zero data no change", v, 32'h0000_0180);
    wr(12'h014, 32'h4000_0000);
    rd(12'h014, v); chk("R2 set hi", v, 32'h4000_0000);

    // R5 / R6 pending and summary
    periph_lvl = 64'h4000_0000_0000_0080;
    local_lvl  = 8'h05;
    rd(12'h004, v); chk("R5 pend lo", v, 32'h0000_0080);
    rd(12'h008, v); chk("R5 pend hi", v, 32'h4000_0000);
    rd(12'h000, v); chk("R6 summary a", v, 32'h0010_0701);
    chk("R7 irq high", {31'b0, irq_o}, 32'h1);
    wr(12'h010, 32'h0000_0200);
    wr(12'h014, 32'h0020_0000);
    periph_lvl = 64'h0020_0000_0000_0200;
    local_lvl  = 8'h00;
    rd(12'h000, v); chk("R6 summary b", v, 32'h0000_8B00);
    periph_lvl = 64'h1;
    local_lvl  = 8'h04;
    @(negedge clk);
    rd(12'h000, v); chk("R6 masked-off summary", v, 32'h0);
    chk("R7 masked-off irq", {31'b0, irq_o}, 32'h0);

    // R7 latency and mask change on the same edge
    periph_lvl = '0; local_lvl = 8'h01;
    chk("R7 not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R7 one clock later", {31'b0, irq_o}, 32'h1);
    wr(12'h024, 32'h0000_0001);
    chk("R7 old mask still seen", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R7 drops after disable", {31'b0, irq_o}, 32'h0);

    // R11 inert writes
    local_lvl = 8'h02;
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h012, 32'hFFFF_FFFF);
    rd(12'h010, v); chk("R11 mask lo kept", v, 32'h0000_0380);
    rd(12'h014, v); chk("R11 mask hi kept", v, 32'h4020_0000);
    rd(12'h018, v); chk("R11 mask local kept", v, 32'h0000_0002);
    rd(12'h00C, v); chk("R11 fiq ctrl kept", v, 32'h0);

    // R10 reads
    rd(12'h030, v); chk("R10 unmapped", v, 32'h0);
    rd(12'h012, v); chk("R10 unaligned", v, 32'h0);
    rd(12'h000, v); chk("R10 summary first", v, 32'h0000_0002);
    rd(12'h000, v); chk("R10 summary repeat", v, 32'h0000_0002);
    @(negedge clk);
    chk("R10 idle rdata", bus_rdata, 32'h0);

    // R12 same-cycle write and read
    bus_addr = 12'h010; bus_wdata = 32'h1; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R12 pre-write value", bus_rdata, 32'h0000_0380);
    rd(12'h010, v); chk("R12 post-write value", v, 32'h0000_0381);

    // R1 mid-run reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rd(12'h010, v); chk("R1 mask lo after reset", v, 32'h0);
    rd(12'h018, v); chk("R1 local mask after reset", v, 32'h0);

    // R8 masks ignored by fast line
    wr(12'h00C, 32'h0000_00C1);
    @(negedge clk);
    chk("R8 raw level despite zero mask", {31'b0, fiq_o}, 32'h1);
    chk("R7 irq stays low", {31'b0, irq_o}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule